// File: doc/BRIEF.md
# FIFO-Level Rate-Recovery Loop

This block accepts samples that arrive in irregular bursts and plays them out as a paced stream. The pace tracks the long-term average arrival rate. The samples are held in a small FIFO. A phase accumulator sets the pace: it adds a frequency word on every clock, and each carry out of its top bit pops one sample. A proportional-integral loop adjusts that word. The loop error is the FIFO occupancy minus half the depth. When the FIFO runs fuller than half, the loop raises the read rate. When it runs emptier, the loop lowers it. The integral term removes the residual fill offset that a purely proportional path would leave, so the occupancy settles around half-full. When the writer's average rate drifts slowly, the loop follows it.

The input side is a valid/ready stream. `in_ready` is high whenever the FIFO holds fewer than DEPTH samples. A beat offered with `in_valid` while `in_ready` is low is not stored and is flagged as an overflow, so the writer either honours back-pressure or loses the beat. The output side has no back-pressure: the downstream consumer must take every beat marked by `out_strobe`. The nominal word, the two gain shifts and the integrator limit are configuration inputs, and their values are taken at each control update. The occupancy, the frequency word in use and the integrator are brought out as status. Everything runs on one clock with a synchronous active-high reset.

Top module: `rate_recovery_loop`

## Requirements
- R1: `in_ready` is high exactly when the occupancy `stat_level` is below DEPTH (16 by default). Each beat with `in_valid` and `in_ready` both high is stored and raises `stat_level` by one at the next clock, unless a read happens on the same clock.
- R2: Samples leave in the order they were accepted. A read taken on a clock edge shows `out_strobe` high for one cycle after that edge, with the sample on `out_data`.
- R3: A beat offered while the FIFO is full is discarded, leaves `stat_level` unchanged, and sets `overflow`. `overflow` stays high until reset.
- R4: A read while the FIFO is empty still pulses `out_strobe`. It repeats the previous `out_data` value (zero after reset) and sets `underflow`, which stays high until reset.
- R5: The phase accumulator is ACC_W bits wide (16 by default). It adds the current word on every clock. A carry out of the top bit requests one read on that same edge, so a word W gives W reads per 2^ACC_W clocks. For example, 16384 gives one read every fourth clock.
- R6: The frequency word and the integrator change only on control-update edges. These fall on every 2^UPD_LOG2-th clock edge counted from reset release: edges 16, 32 and so on by default.
- R7: At an update, the error e = stat_level − DEPTH/2 is scaled to s = e·2^ERR_SHIFT (ERR_SHIFT = 10 by default). The integrator becomes I + (s >>> cfg_i_shift). The word becomes cfg_nominal + (s >>> cfg_p_shift) + the new integrator. Both shifts are arithmetic.
- R8: The integrator is held within ±cfg_int_limit.
- R9: The frequency word is clamped to the range 0 to 2^(ACC_W−1). At 0, no reads occur.
- R10: Reset empties the FIFO and clears both flags, `out_data`, `out_strobe`, the integrator and the accumulator. It loads the frequency word with cfg_nominal clamped as in R9.
- R11: Fed by a bursty writer with a steady average rate, the loop settles with the mean occupancy near DEPTH/2. The mean word is then near the writer rate times 2^ACC_W.
- R12: After the writer's average rate changes, the loop settles again at the new rate with the occupancy near DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Input sample |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | FIFO can store a sample |
| out_data | output | DATA_W | Output sample, held between reads |
| out_strobe | output | 1 | One-cycle pulse marking each read |
| cfg_nominal | input | ACC_W | Nominal frequency word |
| cfg_p_shift | input | SH_W | Right shift applied for the proportional path |
| cfg_i_shift | input | SH_W | Right shift applied for the integral path |
| cfg_int_limit | input | ACC_W-1 | Magnitude limit of the integrator |
| stat_level | output | DEPTH_LOG2+1 | FIFO occupancy |
| stat_freq | output | ACC_W | Frequency word in use |
| stat_integ | output | ACC_W | Integrator value, two's complement |
| overflow | output | 1 | Sticky: a beat was dropped at full |
| underflow | output | 1 | Sticky: a read found the FIFO empty |

## Verification
The assertions check the following on every cycle:
- the frequency word stays within its clamp range;
- the integrator stays within its limit;
- the word and the integrator hold between update edges;
- both flags are sticky;
- an unready beat raises the overflow flag;
- the occupancy cannot grow without an accepted beat;
- a read from an empty FIFO repeats the previous output.

Only the bench's scenarios can show the rest. These are the exact arithmetic of a PI update, the exact read count for a given word, and the order of samples through the FIFO. They also include settling near half-full for one average input rate and then for a drifted one.

// File: rtl/rrl_pkg.sv
package rrl_pkg;

  localparam int CALC_W = 32;

  typedef logic signed [CALC_W-1:0] calc_t;

  function automatic calc_t clamp_calc(calc_t v, calc_t lo, calc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/rrl_fifo.sv
module rrl_fifo #(
  parameter int DATA_W     = 8,
  parameter int DEPTH_LOG2 = 4,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int LVL_W     = DEPTH_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_strobe,
  output logic [LVL_W-1:0]  level,
  output logic              ovf_flag,
  output logic              unf_flag
);

  logic [DATA_W-1:0]     store [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr;
  logic [DEPTH_LOG2-1:0] rd_ptr;
  logic [LVL_W-1:0]      level_q;
  logic                  full;
  logic                  empty;
  logic                  wr_ok;
  logic                  rd_ok;

  assign full     = (level_q == LVL_W'(DEPTH));
  assign empty    = (level_q == '0);
  assign wr_ready = ~full;
  assign wr_ok    = wr_valid & ~full;
  assign rd_ok    = rd_req & ~empty;
  assign level    = level_q;

  // storage array: contents need no reset, pointers define validity
  always_ff @(posedge clk) begin
    if (wr_ok) store[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level_q   <= '0;
      rd_data   <= '0;
      rd_strobe <= 1'b0;
      ovf_flag  <= 1'b0;
      unf_flag  <= 1'b0;
    end else begin
      rd_strobe <= rd_req;
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) begin
        rd_data <= store[rd_ptr];
        rd_ptr  <= rd_ptr + 1'b1;
      end
      level_q <= level_q + LVL_W'(wr_ok) - LVL_W'(rd_ok);
      if (wr_valid && full) ovf_flag <= 1'b1;
      if (rd_req && empty)  unf_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/rrl_nco.sv
module rrl_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] freq,
  output logic             tick
);

  logic [ACC_W-1:0] phase;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, phase} + {1'b0, freq};
  assign tick = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else     phase <= sum[ACC_W-1:0];
  end

endmodule

// File: rtl/rrl_pi_ctrl.sv
module rrl_pi_ctrl
  import rrl_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int LVL_W     = 5,
  parameter int HALF_LVL  = 8,
  parameter int ERR_SHIFT = 10,
  parameter int UPD_LOG2  = 4,
  parameter int SH_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LVL_W-1:0]        level,
  input  logic [ACC_W-1:0]        cfg_nominal,
  input  logic [SH_W-1:0]         cfg_p_shift,
  input  logic [SH_W-1:0]         cfg_i_shift,
  input  logic [ACC_W-2:0]        cfg_int_limit,
  output logic [ACC_W-1:0]        freq,
  output logic signed [ACC_W-1:0] integ
);

  localparam calc_t FMAX  = calc_t'(1) <<< (ACC_W - 1);
  localparam calc_t HALFC = calc_t'(HALF_LVL);

  logic [UPD_LOG2-1:0] timer;
  logic                upd;
  calc_t               err;
  calc_t               scaled;
  calc_t               p_term;
  calc_t               i_term;
  calc_t               lim;
  calc_t               integ_n;
  calc_t               freq_n;
  calc_t               nom_clamped;

  assign upd = &timer;

  always_comb begin
    err         = calc_t'(level) - HALFC;
    scaled      = err <<< ERR_SHIFT;
    p_term      = scaled >>> cfg_p_shift;
    i_term      = scaled >>> cfg_i_shift;
    lim         = calc_t'(cfg_int_limit);
    integ_n     = clamp_calc(calc_t'(integ) + i_term, -lim, lim);
    freq_n      = clamp_calc(calc_t'(cfg_nominal) + p_term + integ_n, '0, FMAX);
    nom_clamped = clamp_calc(calc_t'(cfg_nominal), '0, FMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= '0;
      integ <= '0;
      freq  <= ACC_W'(nom_clamped);
    end else begin
      timer <= timer + 1'b1;
      if (upd) begin
        integ <= ACC_W'(integ_n);
        freq  <= ACC_W'(freq_n);
      end
    end
  end

endmodule

// File: rtl/rate_recovery_loop.sv
module rate_recovery_loop #(
  parameter int DATA_W     = 8,
  parameter int DEPTH_LOG2 = 4,
  parameter int ACC_W      = 16,
  parameter int UPD_LOG2   = 4,
  parameter int ERR_SHIFT  = 10,
  parameter int SH_W       = 4,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int LVL_W     = DEPTH_LOG2 + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic [DATA_W-1:0]       out_data,
  output logic                    out_strobe,
  input  logic [ACC_W-1:0]        cfg_nominal,
  input  logic [SH_W-1:0]         cfg_p_shift,
  input  logic [SH_W-1:0]         cfg_i_shift,
  input  logic [ACC_W-2:0]        cfg_int_limit,
  output logic [LVL_W-1:0]        stat_level,
  output logic [ACC_W-1:0]        stat_freq,
  output logic signed [ACC_W-1:0] stat_integ,
  output logic                    overflow,
  output logic                    underflow
);

  logic read_tick;

  rrl_fifo #(
    .DATA_W    (DATA_W),
    .DEPTH_LOG2(DEPTH_LOG2)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (in_data),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .rd_req   (read_tick),
    .rd_data  (out_data),
    .rd_strobe(out_strobe),
    .level    (stat_level),
    .ovf_flag (overflow),
    .unf_flag (underflow)
  );

  rrl_pi_ctrl #(
    .ACC_W    (ACC_W),
    .LVL_W    (LVL_W),
    .HALF_LVL (DEPTH / 2),
    .ERR_SHIFT(ERR_SHIFT),
    .UPD_LOG2 (UPD_LOG2),
    .SH_W     (SH_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .level        (stat_level),
    .cfg_nominal  (cfg_nominal),
    .cfg_p_shift  (cfg_p_shift),
    .cfg_i_shift  (cfg_i_shift),
    .cfg_int_limit(cfg_int_limit),
    .freq         (stat_freq),
    .integ        (stat_integ)
  );

  rrl_nco #(
    .ACC_W(ACC_W)
  ) u_nco (
    .clk (clk),
    .rst (rst),
    .freq(stat_freq),
    .tick(read_tick)
  );

endmodule

// File: rtl/rrl_checker.sv
module rrl_checker #(
  parameter int DATA_W     = 8,
  parameter int DEPTH_LOG2 = 4,
  parameter int ACC_W      = 16,
  parameter int UPD_LOG2   = 4,
  localparam int DEPTH     = 1 << DEPTH_LOG2,
  localparam int LVL_W     = DEPTH_LOG2 + 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [DATA_W-1:0]       out_data,
  input logic                    out_strobe,
  input logic [ACC_W-2:0]        cfg_int_limit,
  input logic [LVL_W-1:0]        stat_level,
  input logic [ACC_W-1:0]        stat_freq,
  input logic signed [ACC_W-1:0] stat_integ,
  input logic                    overflow,
  input logic                    underflow
);

  logic [UPD_LOG2-1:0] since_upd;

  always_ff @(posedge clk) begin
    if (rst) since_upd <= '0;
    else     since_upd <= since_upd + 1'b1;
  end

  // R9
  freq_range_chk: assert property (@(posedge clk) disable iff (rst)
    stat_freq <= (ACC_W'(1) << (ACC_W - 1)));

  // R8
  integ_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_integ <= $signed({1'b0, cfg_int_limit})) &&
    (stat_integ >= -$signed({1'b0, cfg_int_limit})));

  // R6
  freq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (since_upd != '0) |-> ($stable(stat_freq) && $stable(stat_integ)));

  // R3
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R3
  dropped_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> overflow);

  // R4
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  // R1
  level_growth_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> (stat_level <= $past(stat_level)));

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stat_level <= LVL_W'(DEPTH));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (out_strobe && ($past(stat_level) == '0)) |-> ($stable(out_data) && underflow));

endmodule

bind rate_recovery_loop rrl_checker #(
  .DATA_W    (DATA_W),
  .DEPTH_LOG2(DEPTH_LOG2),
  .ACC_W     (ACC_W),
  .UPD_LOG2  (UPD_LOG2)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_data     (out_data),
  .out_strobe   (out_strobe),
  .cfg_int_limit(cfg_int_limit),
  .stat_level   (stat_level),
  .stat_freq    (stat_freq),
  .stat_integ   (stat_integ),
  .overflow     (overflow),
  .underflow    (underflow)
);

// File: tb/rate_recovery_loop_tb.sv
module rate_recovery_loop_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [7:0]         in_data = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [7:0]         out_data;
  logic               out_strobe;
  logic [15:0]        cfg_nominal = 16'd16384;
  logic [3:0]         cfg_p_shift = 4'd15;
  logic [3:0]         cfg_i_shift = 4'd15;
  logic [14:0]        cfg_int_limit = 15'd1000;
  logic [4:0]         stat_level;
  logic [15:0]        stat_freq;
  logic signed [15:0] stat_integ;
  logic               overflow;
  logic               underflow;

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;
  logic [7:0] sent [16];

  always #4 clk = ~clk;

  rate_recovery_loop u_dut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_strobe(out_strobe),
    .cfg_nominal(cfg_nominal), .cfg_p_shift(cfg_p_shift),
    .cfg_i_shift(cfg_i_shift), .cfg_int_limit(cfg_int_limit),
    .stat_level(stat_level), .stat_freq(stat_freq), .stat_integ(stat_integ),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int nom, input int ps, input int is, input int lim);
    @(negedge clk);
    cfg_nominal   = 16'(nom);
    cfg_p_shift   = 4'(ps);
    cfg_i_shift   = 4'(is);
    cfg_int_limit = 15'(lim);
    in_valid      = 1'b0;
    rst           = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic count_strobes(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_strobe) cnt++;
    end
  endtask

  task automatic track(input int period, input int settle, input int meas, input int exp_freq);
    longint lvl_sum = 0;
    longint frq_sum = 0;
    longint mean_f;
    for (int c = 0; c < settle + meas; c++) begin
      in_valid = ((c % period) < 4);
      in_data  = 8'(c);
      @(negedge clk);
      if (c >= settle) begin
        lvl_sum += longint'(stat_level);
        frq_sum += longint'(stat_freq);
      end
    end
    in_valid = 1'b0;
    mean_f = frq_sum / meas;
    chk(lvl_sum >= 6 * longint'(meas) && lvl_sum <= 10 * longint'(meas),
        "R11/R12 mean level x1000", (lvl_sum * 1000) / meas, 8000);
    chk(mean_f >= exp_freq - 400 && mean_f <= exp_freq + 400,
        "R11/R12 mean frequency word", mean_f, exp_freq);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : main
    int cnt;
    int popped;
    int repeats;

    // R10: reset state, nominal 16384
    do_reset(16384, 15, 15, 1000);
    chk(stat_level == 0, "R10 level", stat_level, 0);
    chk(stat_freq == 16384, "R10 freq", stat_freq, 16384);
    chk(stat_integ == 0, "R10 integ", stat_integ, 0);
    chk(!overflow && !underflow, "R10 flags", {overflow, underflow}, 0);
    chk(in_ready && !out_strobe && out_data == 0, "R10 ready/strobe/data", out_data, 0);

    // R5: 16384 -> 4 reads in first 16 clocks; R6: word held until edge 16
    cnt = 0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (out_strobe) cnt++;
      if (i == 15) chk(stat_freq == 16384, "R6 word held before update", stat_freq, 16384);
    end
    chk(cnt == 4, "R5 reads at word 16384", cnt, 4);
    // R7: e=-8, s=-8192, i: -8192>>>15=-1, p: -1 -> 16384-1-1
    chk(stat_freq == 16382, "R7 word after update", stat_freq, 16382);
    chk(stat_integ == -1, "R7 integ after update", stat_integ, -1);
    // R4: reads from empty repeat zero and flag
    chk(underflow, "R4 underflow flag", underflow, 1);
    chk(out_data == 0, "R4 repeated data", out_data, 0);

    // R5: 8192 -> 2 reads in 16 clocks
    do_reset(8192, 15, 15, 1000);
    count_strobes(16, cnt);
    chk(cnt == 2, "R5 reads at word 8192", cnt, 2);

    // R7/R6: proportional shift 2
    do_reset(16384, 2, 15, 1000);
    repeat (16) @(negedge clk);
    chk(stat_freq == 14335, "R7 p-term word", stat_freq, 14335);
    chk(stat_integ == -1, "R7 integ first", stat_integ, -1);
    repeat (15) @(negedge clk);
    chk(stat_freq == 14335, "R6 word held between updates", stat_freq, 14335);
    @(negedge clk);
    chk(stat_integ == -2, "R7 integ second", stat_integ, -2);
    chk(stat_freq == 14334, "R7 word second", stat_freq, 14334);

    // R9/R10: nominal above half range is clamped at reset and at updates
    do_reset(60000, 15, 15, 1000);
    chk(stat_freq == 32768, "R9 reset clamp high", stat_freq, 32768);
    repeat (16) @(negedge clk);
    chk(stat_freq == 32768, "R9 update clamp high", stat_freq, 32768);

    // R8/R9: integrator negative limit, word clamped at zero
    do_reset(0, 15, 0, 3000);
    repeat (16) @(negedge clk);
    chk(stat_integ == -3000, "R8 integ low limit", stat_integ, -3000);
    chk(stat_freq == 0, "R9 word clamp low", stat_freq, 0);
    for (int i = 0; i < 16; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(i);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (48) @(negedge clk);
    chk(stat_integ == 3000, "R8 integ high limit", stat_integ, 3000);

    // R1/R3: fill with the word stuck at zero (no reads)
    do_reset(0, 15, 15, 1000);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      sent[i]  = 8'(i * 37 + 5);
      in_data  = sent[i];
      in_valid = 1'b1;
      chk(in_ready, "R1 ready below full", in_ready, 1);
      @(negedge clk);
      if (out_strobe) cnt++;
      chk(stat_level == 5'(i + 1), "R1 level increment", stat_level, i + 1);
    end
    chk(!in_ready, "R1 not ready at full", in_ready, 0);
    chk(!overflow, "R3 no overflow yet", overflow, 0);
    in_data = 8'hEE;
    @(negedge clk);
    in_valid = 1'b0;
    chk(stat_level == 16, "R3 dropped beat keeps level", stat_level, 16);
    chk(overflow, "R3 overflow flag", overflow, 1);
    repeat (20) @(negedge clk);
    chk(overflow, "R3 overflow sticky", overflow, 1);
    chk(stat_freq == 0 && cnt == 0, "R9 zero word gives no reads", stat_freq, 0);

    // R2/R4: drain in order, then repeat last sample
    cfg_nominal = 16'd16384;
    popped  = 0;
    repeats = 0;
    for (int i = 0; i < 800 && repeats < 2; i++) begin
      @(negedge clk);
      if (out_strobe) begin
        if (popped < 16) begin
          chk(out_data == sent[popped], "R2 output order", out_data, sent[popped]);
          popped++;
        end else begin
          chk(out_data == sent[15], "R4 repeat last sample", out_data, sent[15]);
          chk(underflow, "R4 underflow after drain", underflow, 1);
          repeats++;
        end
      end
    end
    chk(popped == 16 && repeats == 2, "R2 all samples read", popped, 16);

    // R11: bursty writer 4 beats per 30 clocks -> 65536*4/30
    do_reset(8192, 1, 6, 16000);
    track(30, 30000, 15000, 8738);
    // R12: rate drifts to 4 beats per 34 clocks -> 65536*4/34
    track(34, 30000, 15000, 7710);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule